// File: doc/BRIEF.md
# Twos-Complement Add/Subtract/Negate Unit

This block is an integer arithmetic unit for N-bit twos-complement values. The default width is 8 bits. A 2-bit function code picks one of four operations: sum, difference, negation of operand A, or A passed through unchanged. Every operation runs through one shared ripple adder. Subtraction feeds the adder with A and the bit-inverted B and sets a carry-in of one. Negation feeds it with zero and the bit-inverted A, again with a carry-in of one. There is no separate subtractor.

Along with the N-bit result, the unit gives operand A widened to 2N bits by copying its sign bit into the upper half. It also raises an overflow flag. For sums and differences the flag comes from the sign bits of the values the adder actually receives. For negation the flag is set when a nonzero operand keeps its sign bit, which happens only for the most negative value.

All outputs are registered. Inputs sampled at one rising clock edge appear on the outputs right after that edge. A synchronous active-high reset clears every output. The representable range is -2^(N-1) to 2^(N-1)-1, which is -128..+127 at the default width.

Top module: `tc_arith_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_o`, `wide_o` and `ovf_o` are all zero after that edge.
- R2: With `op_i` = 2'b00 (add), `res_o` after the edge equals (A + B) modulo 2^N.
- R3: With `op_i` = 2'b01 (subtract), `res_o` equals (A - B) modulo 2^N.
- R4: With `op_i` = 2'b10 (negate), `res_o` equals (~A + 1) modulo 2^N.
- R5: With `op_i` = 2'b11 (pass), `res_o` equals A and `ovf_o` is 0.
- R6: For add with operands of the same sign, `ovf_o` is 1 exactly when the sign bit of the result differs from the operands' sign bit.
- R7: For add with operands of opposite sign, `ovf_o` is always 0.
- R8: For subtract, `ovf_o` is 1 exactly when the true difference A - B lies outside -2^(N-1)..2^(N-1)-1. This includes B equal to the most negative value.
- R9: Negating zero gives zero with `ovf_o` = 0.
- R10: Negating the most negative value (sign bit 1, all other bits 0) returns the same pattern with `ovf_o` = 1. Every other negation gives `ovf_o` = 0.
- R11: For every function code, `wide_o` equals A sign-extended to 2N bits: the upper N bits all equal A's bit N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Function code: 00 add, 01 subtract, 10 negate A, 11 pass A |
| a_i | input | N | Operand A, twos complement |
| b_i | input | N | Operand B, twos complement |
| res_o | output | N | Registered N-bit result |
| wide_o | output | 2N | Registered sign extension of A |
| ovf_o | output | 1 | Registered overflow flag |

## Verification
A 4-bit instance is swept over every pair of operands for add and subtract. The expected sums, differences and overflow flags come from signed integer arithmetic in the bench. This separates same-sign sums that wrap from opposite-sign sums that never wrap, and it catches subtraction of the most negative value, where an overflow rule based on the raw B would go wrong. Negate and pass are swept over every A, so zero, the most negative value and the ordinary values are each tried and told apart. Sign extension is compared on every vector, so both positive and negative A are covered. Reset is applied at the start and again after the sweep.

// File: rtl/tc_pkg.sv
package tc_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_NEG  = 2'b10,
    OP_PASS = 2'b11
  } tc_op_e;
endpackage

// File: rtl/tc_operand_prep.sv
module tc_operand_prep
  import tc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [1:0]   op,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] x,
  output logic [N-1:0] y,
  output logic         cin
);
  timeunit 1ns;
  timeprecision 1ps;

  // Steer operands so every function uses the same adder.
  always_comb begin
    x   = a;
    y   = '0;
    cin = 1'b0;
    unique case (tc_op_e'(op))
      OP_ADD:  begin x = a;  y = b;  cin = 1'b0; end
      OP_SUB:  begin x = a;  y = ~b; cin = 1'b1; end
      OP_NEG:  begin x = '0; y = ~a; cin = 1'b1; end
      OP_PASS: begin x = a;  y = '0; cin = 1'b0; end
      default: begin x = a;  y = '0; cin = 1'b0; end
    endcase
  end
endmodule

// File: rtl/tc_ripple_adder.sv
module tc_ripple_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         cin,
  output logic [N-1:0] sum
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [N:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sum[i]     = x[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
  end

  // The carry out of the top bit is dropped on purpose.
  logic unused_cout;
  assign unused_cout = carry[N];
endmodule

// File: rtl/tc_overflow_detect.sv
module tc_overflow_detect
  import tc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [1:0]   op,
  input  logic [N-1:0] a,
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic [N-1:0] sum,
  output logic         ovf
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int MSB = N - 1;

  logic sign_rule;
  logic neg_stuck;

  // Adder inputs share a sign but the sum does not.
  assign sign_rule = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  // A nonzero negation whose sign bit failed to change.
  assign neg_stuck = (a != '0) && (sum[MSB] == a[MSB]);

  always_comb begin
    unique case (tc_op_e'(op))
      OP_ADD, OP_SUB: ovf = sign_rule;
      OP_NEG:         ovf = neg_stuck;
      default:        ovf = 1'b0;
    endcase
  end
endmodule

// File: rtl/tc_sign_widen.sv
module tc_sign_widen #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  output logic [2*N-1:0] wide
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W = 2 * N;

  for (genvar i = 0; i < W; i++) begin : g_ext
    if (i < N) begin : g_low
      assign wide[i] = a[i];
    end else begin : g_high
      assign wide[i] = a[N-1];
    end
  end
endmodule

// File: rtl/tc_arith_unit.sv
module tc_arith_unit #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     op_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [N-1:0]   res_o,
  output logic [2*N-1:0] wide_o,
  output logic           ovf_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W = 2 * N;

  logic [N-1:0] add_x, add_y, add_sum;
  logic         add_cin;
  logic         ovf_d;
  logic [W-1:0] wide_d;

  tc_operand_prep #(.N(N)) u_prep (
    .op(op_i), .a(a_i), .b(b_i), .x(add_x), .y(add_y), .cin(add_cin)
  );

  tc_ripple_adder #(.N(N)) u_adder (
    .x(add_x), .y(add_y), .cin(add_cin), .sum(add_sum)
  );

  tc_overflow_detect #(.N(N)) u_ovf (
    .op(op_i), .a(a_i), .x(add_x), .y(add_y), .sum(add_sum), .ovf(ovf_d)
  );

  tc_sign_widen #(.N(N)) u_widen (
    .a(a_i), .wide(wide_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      wide_o <= '0;
      ovf_o  <= 1'b0;
    end else begin
      res_o  <= add_sum;
      wide_o <= wide_d;
      ovf_o  <= ovf_d;
    end
  end
endmodule

// File: rtl/tc_arith_checker.sv
module tc_arith_checker #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     op,
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic [N-1:0]   res,
  input logic [2*N-1:0] wide,
  input logic           ovf
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};

  // Set once a full cycle out of reset has loaded the output registers.
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (res == '0 && wide == '0 && !ovf)); // R1

  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op) == 2'b00 |-> res == N'($past(a) + $past(b))); // R2

  AST_SUB_RESULT: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op) == 2'b01 |-> res == N'($past(a) - $past(b))); // R3

  AST_PASS_VALUE: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op) == 2'b11 |-> (res == $past(a) && !ovf)); // R5

  AST_SAME_SIGN_ADD: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op) == 2'b00 && $past(a[N-1]) == $past(b[N-1])
    |-> ovf == (res[N-1] != $past(a[N-1]))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op) == 2'b00 && $past(a[N-1]) != $past(b[N-1])
    |-> !ovf); // R7

  AST_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op) == 2'b10 && $past(a) == '0
    |-> (res == '0 && !ovf)); // R9

  AST_NEG_MOST_NEG: assert property (@(posedge clk) disable iff (rst)
    armed && $past(op) == 2'b10 && $past(a) == MOST_NEG
    |-> (res == MOST_NEG && ovf)); // R10

  AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (rst)
    armed |-> (wide[N-1:0] == $past(a) &&
               (wide[2*N-1:N] == '0 || wide[2*N-1:N] == '1) &&
               wide[2*N-1] == $past(a[N-1]))); // R11
endmodule

bind tc_arith_unit tc_arith_checker #(.N(N)) u_tc_arith_checker (
  .clk(clk), .rst(rst), .op(op_i), .a(a_i), .b(b_i),
  .res(res_o), .wide(wide_o), .ovf(ovf_o)
);

// File: tb/test_tc_arith_unit.sv
module test_tc_arith_unit;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N    = 4;
  localparam int MOD  = 1 << N;
  localparam int HALF = 1 << (N - 1);
  localparam int WMOD = 1 << (2 * N);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     op_i = 2'b00;
  logic [N-1:0]   a_i = '0;
  logic [N-1:0]   b_i = '0;
  logic [N-1:0]   res_o;
  logic [2*N-1:0] wide_o;
  logic           ovf_o;

  int runs  = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tc_arith_unit #(.N(N)) i_tc_arith_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .res_o(res_o), .wide_o(wide_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (op=%0d a=%0d b=%0d)",
               tag, what, act, exp, op_i, a_i, b_i);
    end
  endtask

  function automatic int to_signed(input int v);
    return (v >= HALF) ? v - MOD : v;
  endfunction

  task automatic run_vec(input int op, input int av, input int bv);
    int sa, sb, exact, exp_res, exp_ovf, exp_wide;
    string rtag, otag;
    @(negedge clk);
    op_i = op[1:0];
    a_i  = av[N-1:0];
    b_i  = bv[N-1:0];
    sa = to_signed(av);
    sb = to_signed(bv);
    case (op)
      0: begin exact = sa + sb; rtag = "R2"; otag = ((sa < 0) != (sb < 0)) ? "R7" : "R6"; end
      1: begin exact = sa - sb; rtag = "R3"; otag = "R8"; end
      2: begin exact = -sa; rtag = (av == 0) ? "R9" : "R4"; otag = (av == 0) ? "R9" : "R10"; end
      default: begin exact = sa; rtag = "R5"; otag = "R5"; end
    endcase
    exp_res  = ((exact % MOD) + MOD) % MOD;
    exp_ovf  = (exact > HALF - 1 || exact < -HALF) ? 1 : 0;
    exp_wide = (sa + WMOD) % WMOD;
    @(negedge clk);
    chk(rtag, "res", int'(res_o), exp_res);
    chk(otag, "ovf", int'(ovf_o), exp_ovf);
    chk("R11", "wide", int'(wide_o), exp_wide);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    a_i = '1;
    b_i = '1;
    op_i = 2'b10;
    repeat (3) @(negedge clk);
    chk("R1", "res", int'(res_o), 0);
    chk("R1", "wide", int'(wide_o), 0);
    chk("R1", "ovf", int'(ovf_o), 0);
    rst = 1'b0;

    for (int op = 0; op < 2; op++)
      for (int av = 0; av < MOD; av++)
        for (int bv = 0; bv < MOD; bv++)
          run_vec(op, av, bv);

    for (int op = 2; op < 4; op++)
      for (int av = 0; av < MOD; av++)
        run_vec(op, av, (av * 5 + 3) % MOD);

    // R10: explicit most-negative negation
    run_vec(2, HALF, 0);

    // R1: reset again after activity
    @(negedge clk);
    op_i = 2'b10;
    a_i  = N'(HALF);
    rst  = 1'b1;
    @(negedge clk);
    chk("R1", "res", int'(res_o), 0);
    chk("R1", "wide", int'(wide_o), 0);
    chk("R1", "ovf", int'(ovf_o), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule